// File: doc/BRIEF.md
# Four-Channel Programmable Down-Counter Timer

This block is a memory-mapped timer unit with four independent decrementing counters that share one interrupt line. Software gives each counter a start value, a reload value for later periods, a clock divider, a width of 16 or 32 bits, and one of three behaviours at zero: reload from the reload value, wrap to all ones, or stop.

Each counter sets its own raw interrupt bit when a tick brings its count down to zero. A mask register selects which raw bits drive the single interrupt output. A write-one-to-clear register acknowledges them. The host port is a synchronous write strobe with address and data. Read data follows the address combinationally, and each counter's live value can be read at any time.

Top module: `quad_down_timer`

## Requirements
- R1: After synchronous reset every register reads as zero and `irq_o` is low.
- R2: A write to a counter's load register (sub-offset 0x0) sets the live count and the reload value to the written data at that clock edge. The load register reads back the full written word.
- R3: A write to the reload register (sub-offset 0xC) changes only the reload value. The live count is not disturbed, and the new value is used at the next reload from zero.
- R4: Control bit 7 starts the counter. Bits 3:2 pick the tick rate: 00 decrements on every clock, 01 on every 16th clock and 10 or 11 on every 256th clock. With 00, 01 and 10, the first decrement comes 1, 16 or 256 clocks after the enabling write.
- R5: Clearing control bit 7 freezes the live count and restarts the divider phase, so that the next enable again waits a full divider period. The value register (sub-offset 0x4) returns the live count.
- R6: With bit 6 set and bit 0 clear, the first tick after the count reaches zero loads the reload value.
- R7: With bit 6 and bit 0 both clear, the first tick after zero loads the all-ones value of the current width.
- R8: With bit 0 set, a counter that reaches zero stays at zero whatever bit 6 holds.
- R9: With control bit 1 clear, the counter uses only the low 16 bits. The value register reads with its upper 16 bits at zero.
- R10: Bit n of the raw status register (0x04) is set by the tick that brings counter n to zero. Writing 1 to bit n of the clear register (0x0C) clears it, a set in the same cycle wins, and writes to 0x04 are ignored.
- R11: The mask register (0x00) is read/write. The masked status (0x08) equals raw AND mask, and `irq_o` is high exactly when the masked status is non-zero.
- R12: Counter n's registers sit at 0x10 + 0x10*n. The control register keeps bits 7:6 and 3:0 and reads bits 5:4 as zero. Address bits 1:0 are ignored, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rd_data | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | OR of the masked status bits |

## Verification
The step and hold properties assume that the control register is not rewritten in the same cycle as a counting tick. A width change in that cycle would alter the masked count, so those cycles are left out of the antecedents. The stimulus writes a control register only to start or stop a counter, and stops one before changing its width or divider. Sweeps run every counter with every divider code over a fixed window, and the expected counts are computed arithmetically from the number of elapsed clocks.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

    localparam int QDT_DATA_W   = 32;
    localparam int QDT_NARROW_W = 16;
    localparam int QDT_NUM_CH   = 4;
    localparam int QDT_ADDR_W   = 8;
    localparam int QDT_PRE_W    = 8;
    localparam int CTRL_W       = 8;

    // control word, bit 7 down to bit 0
    typedef struct packed {
        logic       run;          // 7: counting enabled
        logic       reload_mode;  // 6: 1 reload from reload value, 0 wrap to all ones
        logic [1:0] spare;        // 5:4 read as zero
        logic [1:0] div_sel;      // 3:2 divider code
        logic       wide;         // 1: full width, else narrow
        logic       single;       // 0: stop at zero
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        DIV_1    = 2'b00,
        DIV_16   = 2'b01,
        DIV_256  = 2'b10,
        DIV_256B = 2'b11
    } div_sel_e;

    typedef enum logic [1:0] {
        SUB_LOAD  = 2'd0,
        SUB_VALUE = 2'd1,
        SUB_CTRL  = 2'd2,
        SUB_BG    = 2'd3
    } chan_sub_e;

    typedef enum logic [1:0] {
        IRQ_MASK   = 2'd0,
        IRQ_RAW    = 2'd1,
        IRQ_MASKED = 2'd2,
        IRQ_CLEAR  = 2'd3
    } irq_sub_e;

    function automatic logic [QDT_DATA_W-1:0] width_mask(input logic wide);
        width_mask = wide ? {QDT_DATA_W{1'b1}}
                          : {{(QDT_DATA_W-QDT_NARROW_W){1'b0}}, {QDT_NARROW_W{1'b1}}};
    endfunction

    function automatic tmr_ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        tmr_ctrl_t c;
        c       = tmr_ctrl_t'(w);
        c.spare = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler
    import qdt_pkg::*;
#(
    parameter int PRE_W = QDT_PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);
    localparam int MID_W = 4;

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) phase_q <= '0;
        else             phase_q <= phase_q + PRE_W'(1);
    end

    always_comb begin
        tick = 1'b0;
        if (run) begin
            case (div_sel)
                DIV_1:   tick = 1'b1;
                DIV_16:  tick = (phase_q[MID_W-1:0] == {MID_W{1'b1}});
                default: tick = (phase_q == {PRE_W{1'b1}});
            endcase
        end
    end

    // R4: after a divided tick the low phase nibble restarts
    p_phase_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel == DIV_16) |=> (phase_q[MID_W-1:0] == '0));

    // R5: a stopped divider holds phase zero
    p_phase_stop_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_q == '0));

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int DATA_W = QDT_DATA_W,
    parameter int PRE_W  = QDT_PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic              bg_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] bg_q,
    output tmr_ctrl_t         ctrl_q,
    output logic [DATA_W-1:0] cnt_o,
    output logic              zero_evt
);
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] count_d;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] cnt_m;
    logic              at_zero;
    logic              tick;

    qdt_prescaler #(.PRE_W(PRE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    assign wmask   = width_mask(ctrl_q.wide);
    assign cnt_m   = count_q & wmask;
    assign at_zero = (cnt_m == '0);
    assign cnt_o   = cnt_m;

    always_comb begin
        count_d  = count_q;
        zero_evt = 1'b0;
        if (load_we) begin
            count_d = wdata;
        end else if (tick) begin
            if (!at_zero) begin
                count_d  = cnt_m - DATA_W'(1);
                zero_evt = (cnt_m == DATA_W'(1));
            end else if (ctrl_q.single) begin
                count_d = count_q;
            end else if (ctrl_q.reload_mode) begin
                count_d = bg_q;
            end else begin
                count_d = wmask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            load_q  <= '0;
            bg_q    <= '0;
            ctrl_q  <= '0;
        end else begin
            count_q <= count_d;
            if (load_we) begin
                load_q <= wdata;
                bg_q   <= wdata;
            end else if (bg_we) begin
                bg_q <= wdata;
            end
            if (ctrl_we) ctrl_q <= ctrl_from_word(wdata[CTRL_W-1:0]);
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (count_q == $past(wdata)) && (bg_q == $past(wdata)));

    p_bg_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (bg_we && !load_we && !tick) |=> (count_q == $past(count_q)));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !at_zero && !load_we && !ctrl_we) |=> (cnt_o == $past(cnt_m) - DATA_W'(1)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !load_we) |=> (count_q == $past(count_q)));

    p_oneshot_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.single && at_zero && !load_we && !ctrl_we) |=> at_zero);

    p_narrow_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.wide |-> (cnt_o[DATA_W-1:QDT_NARROW_W] == '0));

endmodule

// File: rtl/qdt_irq_ctrl.sv
module qdt_irq_ctrl
    import qdt_pkg::*;
#(
    parameter int NUM_CH = QDT_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] set_evt,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mis_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;
    assign mis_o    = raw_q & mask_q;
    assign irq_o    = |mis_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | set_evt;
            if (mask_we) mask_q <= wdata;
        end
    end

    p_mask_wr_r11: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(wdata)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        p_set_r10: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> raw_q[i]);
        p_clear_r10: assert property (@(posedge clk) disable iff (rst)
            (clr_we && wdata[i] && !set_evt[i]) |=> !raw_q[i]);
        p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            (raw_q[i] && !(clr_we && wdata[i])) |=> raw_q[i]);
    end

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int NUM_CH = QDT_NUM_CH,
    parameter int DATA_W = QDT_DATA_W,
    parameter int ADDR_W = QDT_ADDR_W,
    parameter int PRE_W  = QDT_PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              irq_o
);
    localparam int REG_W = ADDR_W - 4;

    logic [REG_W-1:0] region;
    logic [1:0]       sub;
    logic             unused_addr_lsb;

    assign region          = reg_addr[ADDR_W-1:4];
    assign sub             = reg_addr[3:2];
    assign unused_addr_lsb = ^reg_addr[1:0];

    logic [NUM_CH-1:0] ld_we, bg_we, ctrl_we, zero_evt;
    logic [DATA_W-1:0] ld_arr  [NUM_CH];
    logic [DATA_W-1:0] bg_arr  [NUM_CH];
    logic [DATA_W-1:0] cnt_arr [NUM_CH];
    tmr_ctrl_t         ctrl_arr[NUM_CH];

    logic              shared_sel;
    logic [NUM_CH-1:0] mask_q, raw_q, mis;

    assign shared_sel = (region == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit        = (region == REG_W'(c + 1));
        assign ld_we[c]   = reg_wr && hit && (sub == SUB_LOAD);
        assign ctrl_we[c] = reg_wr && hit && (sub == SUB_CTRL);
        assign bg_we[c]   = reg_wr && hit && (sub == SUB_BG);

        qdt_channel #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .load_we  (ld_we[c]),
            .bg_we    (bg_we[c]),
            .ctrl_we  (ctrl_we[c]),
            .wdata    (reg_wdata),
            .load_q   (ld_arr[c]),
            .bg_q     (bg_arr[c]),
            .ctrl_q   (ctrl_arr[c]),
            .cnt_o    (cnt_arr[c]),
            .zero_evt (zero_evt[c])
        );
    end

    qdt_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (reg_wr && shared_sel && (sub == IRQ_MASK)),
        .clr_we  (reg_wr && shared_sel && (sub == IRQ_CLEAR)),
        .wdata   (reg_wdata[NUM_CH-1:0]),
        .set_evt (zero_evt),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .mis_o   (mis),
        .irq_o   (irq_o)
    );

    always_comb begin
        reg_rd_data = '0;
        if (shared_sel) begin
            case (sub)
                IRQ_MASK:   reg_rd_data[NUM_CH-1:0] = mask_q;
                IRQ_RAW:    reg_rd_data[NUM_CH-1:0] = raw_q;
                IRQ_MASKED: reg_rd_data[NUM_CH-1:0] = mis;
                default:    reg_rd_data = '0;
            endcase
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (region == REG_W'(c + 1)) begin
                    case (sub)
                        SUB_LOAD:  reg_rd_data = ld_arr[c];
                        SUB_VALUE: reg_rd_data = cnt_arr[c];
                        SUB_CTRL:  reg_rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_arr[c]};
                        default:   reg_rd_data = bg_arr[c];
                    endcase
                end
            end
        end
    end

    // R11: interrupt output follows masked raw state of the irq section
    p_irq_r11: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_q != '0) && (raw_q != '0));

    // R12: at most one channel strobe per write
    p_one_target_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_we | bg_we | ctrl_we));

endmodule

// File: tb/quad_down_timer_tb_top.sv
`timescale 1ns/1ps
module quad_down_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rd_data;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    quad_down_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_wr      (reg_wr),
        .reg_rd_data (reg_rd_data),
        .irq_o       (irq_o)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rd_data;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        n_cmp++;
        if (v !== exp) begin
            n_bad++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, v, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        n_cmp++;
        if (irq_o !== exp) begin
            n_bad++;
            $display("FAIL %s irq_o: actual %b expected %b", tag, irq_o, exp);
        end
    endtask

    initial begin
        logic [31:0] v0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);

        // R1: reset state
        for (int a = 0; a < 20; a++) chk(8'(a * 4), 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R4 sweep: every channel, every divider code; R5 freeze afterwards
        for (int ch = 0; ch < 4; ch++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] base;
                int div;
                base = 8'h10 + 8'(ch * 16);
                div  = (p == 0) ? 1 : ((p == 1) ? 16 : 256);
                wr(base, 32'd1000);
                wr(base + 8'h8, 32'h82 | 32'h40 | 32'(p << 2));
                wait_cyc(600);
                chk(base + 8'h4, 32'(1000 - 600 / div), "R4");
                wr(base + 8'h8, 32'h0);
                rd(base + 8'h4, v0);
                wait_cyc(40);
                chk(base + 8'h4, v0, "R5");
            end
        end

        // R5: divider phase restarts on re-enable
        wr(8'h10, 32'd100);
        wr(8'h18, 32'h86);
        wait_cyc(10);
        wr(8'h18, 32'h06);
        wr(8'h18, 32'h86);
        wait_cyc(15);
        chk(8'h14, 32'd100, "R5");
        wait_cyc(1);
        chk(8'h14, 32'd99, "R5");
        wr(8'h18, 32'h0);

        // R2 / R3 / R6 / R10: periodic on channel 1
        wr(8'h20, 32'd5);
        wr(8'h2C, 32'd20);
        chk(8'h24, 32'd5, "R3");
        chk(8'h2C, 32'd20, "R3");
        chk(8'h20, 32'd5, "R2");
        wr(8'h28, 32'hC2);
        wait_cyc(4);
        chk(8'h24, 32'd1, "R4");
        chk(8'h04, 32'h0, "R10");
        wait_cyc(1);
        chk(8'h24, 32'd0, "R6");
        chk(8'h04, 32'h2, "R10");
        wait_cyc(1);
        chk(8'h24, 32'd20, "R6");
        wait_cyc(1);
        chk(8'h24, 32'd19, "R6");
        wr(8'h0C, 32'h2);
        chk(8'h04, 32'h0, "R10");
        wr(8'h28, 32'h0);

        // R7: free-running wrap, full width on channel 2
        wr(8'h30, 32'd3);
        wr(8'h38, 32'h82);
        wait_cyc(3);
        chk(8'h34, 32'd0, "R7");
        wait_cyc(1);
        chk(8'h34, 32'hFFFF_FFFF, "R7");
        wait_cyc(1);
        chk(8'h34, 32'hFFFF_FFFE, "R7");
        wr(8'h38, 32'h0);

        // R9: narrow width on channel 3
        wr(8'h40, 32'h00AB_0002);
        chk(8'h44, 32'h0000_0002, "R9");
        chk(8'h40, 32'h00AB_0002, "R2");
        wr(8'h48, 32'h80);
        wait_cyc(2);
        chk(8'h44, 32'd0, "R9");
        wait_cyc(1);
        chk(8'h44, 32'h0000_FFFF, "R9");
        wr(8'h48, 32'h0);
        chk(8'h04, 32'hC, "R10");
        wr(8'h0C, 32'hF);
        chk(8'h04, 32'h0, "R10");

        // R8: one-shot with periodic bit also set
        wr(8'h10, 32'd4);
        wr(8'h18, 32'hC3);
        wait_cyc(4);
        chk(8'h14, 32'd0, "R8");
        chk(8'h04, 32'h1, "R10");
        wait_cyc(20);
        chk(8'h14, 32'd0, "R8");
        chk(8'h04, 32'h1, "R8");

        // R11: mask, masked status, interrupt output
        chk(8'h08, 32'h0, "R11");
        chk_irq(1'b0, "R11");
        wr(8'h00, 32'h1);
        chk(8'h00, 32'h1, "R11");
        chk(8'h08, 32'h1, "R11");
        chk_irq(1'b1, "R11");
        wr(8'h00, 32'h2);
        chk(8'h08, 32'h0, "R11");
        chk_irq(1'b0, "R11");
        wr(8'h04, 32'h0);
        chk(8'h04, 32'h1, "R10");
        wr(8'h00, 32'h1);
        chk_irq(1'b1, "R11");
        wr(8'h0C, 32'h1);
        chk(8'h04, 32'h0, "R10");
        chk_irq(1'b0, "R11");
        wr(8'h18, 32'h0);

        // R12: address map, spare control bits, ignored low address bits
        for (int c = 0; c < 4; c++) wr(8'h10 + 8'(c * 16), 32'h111 * 32'(c + 1));
        for (int c = 0; c < 4; c++) begin
            chk(8'h10 + 8'(c * 16), 32'h111 * 32'(c + 1), "R12");
            chk(8'h14 + 8'(c * 16), 32'h111 * 32'(c + 1), "R12");
            chk(8'h1C + 8'(c * 16), 32'h111 * 32'(c + 1), "R12");
        end
        wr(8'h48, 32'h3F);
        chk(8'h48, 32'h0F, "R12");
        wr(8'h48, 32'h0);
        chk(8'h31, 32'h333, "R12");
        chk(8'h50, 32'h0, "R12");
        chk(8'h0C, 32'h0, "R12");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule